// File: doc/BRIEF.md
# Shift Unit With Status Flags

This block is the shift datapath of a 32-bit integer execution stage. One word is shifted left with zero fill, right with zero fill, or right with the sign bit copied in. The shift amount comes from one of two places: a full register operand, of which only the low five bits count, or a 5-bit immediate field. The shifted word is produced combinationally in the same cycle as the request.

Next to the word, the unit builds four status bits for the processor status word. These are the bit that left the word last, an overflow bit that is always clear, a sign bit and a zero bit. The status bits are captured at the clock edge on which the request is valid. They keep their value while no request is presented, so the status stays with the last shift that was issued.

Top module: `barrel_shift_flags`

## Requirements
- R1: With `shift_right`=0 the result is `data_in` shifted left by the count, with zeros entering at bit 0; `shift_arith` has no effect in this direction.
- R2: With `shift_right`=1 and `shift_arith`=0 the result is `data_in` shifted right by the count, with zeros entering at bit 31 (0x80000000 by 1 gives 0x40000000).
- R3: With `shift_right`=1 and `shift_arith`=1 the vacated upper bits are copies of the old bit 31 (0x80000000 by 1 gives 0xC0000000).
- R4: With `count_use_imm`=1 the count is `count_imm`. With `count_use_imm`=0 the count is bits 4:0 of `count_reg` and bits 31:5 are ignored, so the count wraps modulo 32.
- R5: On the rising edge where `op_valid`=1, `flag_cy` takes the last bit that left the word: bit 32-n of the input for a left shift and bit n-1 for a right shift (0x00000008 right by 4 gives 0 with carry 1).
- R6: A count of zero returns `data_in` unchanged and captures `flag_cy`=0.
- R7: Every captured shift leaves `flag_ov`=0.
- R8: On the same edge `flag_s` takes bit 31 of the result, and `flag_z` is 1 exactly when all 32 result bits are zero.
- R9: On an edge where `op_valid`=0 the four flags keep their values. `flags_valid` is 1 in exactly the cycle that follows an edge on which `op_valid` was 1.
- R10: A clock edge with `rst_n`=0 clears all four flags and `flags_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Request present; the flags are captured on this edge |
| shift_right | input | 1 | 1 shifts toward bit 0, 0 shifts toward bit 31 |
| shift_arith | input | 1 | For right shifts, fills with the old bit 31 |
| count_use_imm | input | 1 | 1 takes the count from `count_imm`, 0 from `count_reg` |
| count_reg | input | 32 | Register count operand; only bits 4:0 are used |
| count_imm | input | 5 | Immediate count |
| data_in | input | 32 | Word to shift |
| result | output | 32 | Shifted word, combinational |
| flag_cy | output | 1 | Last bit shifted out (0 for a zero count) |
| flag_ov | output | 1 | Overflow, always cleared by a shift |
| flag_s | output | 1 | Bit 31 of the captured result |
| flag_z | output | 1 | Captured result was zero |
| flags_valid | output | 1 | Flags were updated on the previous edge |

## Verification
Directed cases cover the points where the three modes differ. A word with only bit 31 set, shifted right by one, tells the sign fill apart from the zero fill. The same word shifted left by one tells a carry-out that empties the word from one that does not. A count of zero on an all-ones word shows that the carry is forced to zero even though shifting would have produced a one. A register count of 33 shows that the upper bits of the count are dropped, and a left shift with the arithmetic select set shows that the select is ignored in that direction. Random words, counts, directions and count sources are then compared against a bit-by-bit reference shift, and idle cycles with changed inputs show that the flags are held.

// File: rtl/shf_pkg.sv
// Package shared by the shift unit: default widths and the flag bundle.
// Assumes a word width that is a power of two.
package shf_pkg;
    localparam int unsigned SHF_W = 32;

    typedef struct packed {
        logic cy;
        logic ov;
        logic s;
        logic z;
    } shf_flags_t;
endpackage

// File: rtl/shf_count_sel.sv
// Count selector: picks the immediate or the register count and keeps only
// the low log2(W) bits of the register operand, so counts wrap modulo W.
// Assumes W is a power of two.
module shf_count_sel #(
    parameter int unsigned W  = shf_pkg::SHF_W,
    localparam int unsigned CW = $clog2(W)
) (
    input  logic          use_imm,
    input  logic [W-1:0]  cnt_reg,
    input  logic [CW-1:0] cnt_imm,
    output logic [CW-1:0] cnt
);
    // The upper register bits do not take part in the count.
    logic unused_cnt_hi;
    assign unused_cnt_hi = ^cnt_reg[W-1:CW];

    // Choose the count source.
    always_comb begin
        cnt = use_imm ? cnt_imm : cnt_reg[CW-1:0];
    end
endmodule

// File: rtl/shf_core.sv
// Shift core: a logarithmic right shifter on a word widened by one guard bit
// below bit 0. After the shift the guard bit holds the last bit shifted out.
// A left shift is done by bit-reversing the word on the way in and out.
// Assumes W is a power of two; a zero count leaves the guard bit at 0.
module shf_core #(
    parameter int unsigned W  = shf_pkg::SHF_W,
    localparam int unsigned CW = $clog2(W)
) (
    input  logic [W-1:0]  data_in,
    input  logic          right,
    input  logic          arith,
    input  logic [CW-1:0] cnt,
    output logic [W-1:0]  result,
    output logic          cy_out
);
    logic [W-1:0] rev_in;
    logic [W-1:0] body;
    logic [W-1:0] rev_body;
    logic [W-1:0] src;
    logic         fill;
    logic [W:0]   stg [0:CW];

    // Bit-reverse the input and the shifter output for left shifts.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev_in[i]   = data_in[W-1-i];
        assign rev_body[i] = body[W-1-i];
    end

    // Fill bit: copy of the old MSB only for an arithmetic right shift.
    always_comb begin
        fill = right & arith & data_in[W-1];
        src  = right ? data_in : rev_in;
    end

    assign stg[0] = {src, 1'b0};

    // One stage per count bit, stage k moves the word by 2**k places.
    for (genvar k = 0; k < CW; k++) begin : g_stage
        localparam int unsigned SH = 1 << k;
        assign stg[k+1] = cnt[k] ? {{SH{fill}}, stg[k][W:SH]} : stg[k];
    end

    // Split the final stage into the word and the shifted-out bit.
    always_comb begin
        body   = stg[CW][W:1];
        cy_out = stg[CW][0];
        result = right ? body : rev_body;
    end
endmodule

// File: rtl/shf_flag_reg.sv
// Flag stage: captures carry, overflow, sign and zero of the current result
// when a request is valid, and holds them otherwise.
// Assumes a synchronous active-low reset.
module shf_flag_reg #(
    parameter int unsigned W = shf_pkg::SHF_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   cy_in,
    input  logic [W-1:0]           res_in,
    output shf_pkg::shf_flags_t    flags,
    output logic                   valid
);
    // Capture or hold the status bits; mark the cycle after a capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            valid <= 1'b0;
        end else begin
            valid <= load;
            if (load) begin
                flags.cy <= cy_in;
                flags.ov <= 1'b0;
                flags.s  <= res_in[W-1];
                flags.z  <= (res_in == '0);
            end
        end
    end
endmodule

// File: rtl/barrel_shift_flags.sv
// Shift unit top: count selection, the shift core and the flag stage.
// The result is combinational; flags are registered on op_valid.
module barrel_shift_flags #(
    parameter int unsigned W  = shf_pkg::SHF_W,
    localparam int unsigned CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic          shift_right,
    input  logic          shift_arith,
    input  logic          count_use_imm,
    input  logic [W-1:0]  count_reg,
    input  logic [CW-1:0] count_imm,
    input  logic [W-1:0]  data_in,
    output logic [W-1:0]  result,
    output logic          flag_cy,
    output logic          flag_ov,
    output logic          flag_s,
    output logic          flag_z,
    output logic          flags_valid
);
    logic [CW-1:0]       cnt;
    logic                cy_raw;
    shf_pkg::shf_flags_t flags;

    shf_count_sel #(.W(W)) u_cnt (
        .use_imm (count_use_imm),
        .cnt_reg (count_reg),
        .cnt_imm (count_imm),
        .cnt     (cnt)
    );

    shf_core #(.W(W)) u_core (
        .data_in (data_in),
        .right   (shift_right),
        .arith   (shift_arith),
        .cnt     (cnt),
        .result  (result),
        .cy_out  (cy_raw)
    );

    shf_flag_reg #(.W(W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (op_valid),
        .cy_in  (cy_raw),
        .res_in (result),
        .flags  (flags),
        .valid  (flags_valid)
    );

    // Unpack the flag bundle onto the ports.
    always_comb begin
        flag_cy = flags.cy;
        flag_ov = flags.ov;
        flag_s  = flags.s;
        flag_z  = flags.z;
    end
endmodule

// File: rtl/shf_checker.sv
// Checker for the shift unit, bound to every instance of the top module.
module shf_checker #(
    parameter int unsigned W  = shf_pkg::SHF_W,
    localparam int unsigned CW = $clog2(W)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic          shift_right,
    input logic          shift_arith,
    input logic          count_use_imm,
    input logic [W-1:0]  count_reg,
    input logic [CW-1:0] count_imm,
    input logic [W-1:0]  data_in,
    input logic [W-1:0]  result,
    input logic          flag_cy,
    input logic          flag_ov,
    input logic          flag_s,
    input logic          flag_z,
    input logic          flags_valid
);
    logic [CW-1:0] eff_cnt;
    logic          unused_chk_hi;
    assign eff_cnt       = count_use_imm ? count_imm : count_reg[CW-1:0];
    assign unused_chk_hi = ^count_reg[W-1:CW];

    assert_sign_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_right && shift_arith && data_in[W-1]) |-> result[W-1]);

    assert_zero_count_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_cnt == '0) |-> (result == data_in));

    assert_zero_count_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && eff_cnt == '0) |=> !flag_cy);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !flag_ov);

    assert_sign_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (flag_s == $past(result[W-1])));

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (flag_z == ($past(result) == '0)));

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable({flag_cy, flag_ov, flag_s, flag_z}));

    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> flags_valid);

    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !flags_valid);
endmodule

bind barrel_shift_flags shf_checker #(.W(W)) u_shf_checker (.*);

// File: tb/tb_barrel_shift_flags.sv
module tb_barrel_shift_flags;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        shift_right = 1'b0;
    logic        shift_arith = 1'b0;
    logic        count_use_imm = 1'b0;
    logic [31:0] count_reg = '0;
    logic [4:0]  count_imm = '0;
    logic [31:0] data_in = '0;
    logic [31:0] result;
    logic        flag_cy, flag_ov, flag_s, flag_z, flags_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    barrel_shift_flags dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
        .shift_right(shift_right), .shift_arith(shift_arith),
        .count_use_imm(count_use_imm), .count_reg(count_reg),
        .count_imm(count_imm), .data_in(data_in), .result(result),
        .flag_cy(flag_cy), .flag_ov(flag_ov), .flag_s(flag_s),
        .flag_z(flag_z), .flags_valid(flags_valid)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Reference: move one bit at a time, remember the bit that leaves.
    function automatic logic [32:0] ref_shift(logic [31:0] d, logic rgt,
                                               logic ari, int n);
        logic [31:0] w = d;
        logic        c = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (rgt) begin
                c = w[0];
                w = {(ari ? w[31] : 1'b0), w[31:1]};
            end else begin
                c = w[31];
                w = {w[30:0], 1'b0};
            end
        end
        return {c, w};
    endfunction

    logic [3:0] last_flags;

    // One request: result checked in the same cycle, flags one edge later.
    task automatic run_op(logic rgt, logic ari, logic imm, logic [31:0] creg,
                          logic [4:0] cimm, logic [31:0] d, string tag);
        int          n;
        logic [32:0] e;
        @(negedge clk);
        shift_right = rgt; shift_arith = ari; count_use_imm = imm;
        count_reg = creg; count_imm = cimm; data_in = d; op_valid = 1'b1;
        n = imm ? int'(cimm) : int'(creg[4:0]);
        e = ref_shift(d, rgt, ari, n);
        #1;
        chk({tag, " result"}, result, e[31:0]);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R5 carry", {31'd0, flag_cy}, {31'd0, e[32]});
        chk("R7 overflow", {31'd0, flag_ov}, 32'd0);
        chk("R8 sign", {31'd0, flag_s}, {31'd0, e[31]});
        chk("R8 zero", {31'd0, flag_z}, {31'd0, e[31:0] == 32'd0});
        chk("R9 valid pulse", {31'd0, flags_valid}, 32'd1);
        last_flags = {e[32], 1'b0, e[31], e[31:0] == 32'd0};
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R10 reset cy", {31'd0, flag_cy}, 32'd0);
        chk("R10 reset ov", {31'd0, flag_ov}, 32'd0);
        chk("R10 reset s", {31'd0, flag_s}, 32'd0);
        chk("R10 reset z", {31'd0, flag_z}, 32'd0);
        chk("R10 reset valid", {31'd0, flags_valid}, 32'd0);
        rst_n = 1'b1;

        run_op(1, 1, 1, 0, 5'd1, 32'h8000_0000, "R3 sign fill");
        chk("R3 directed", result, 32'hC000_0000);
        run_op(1, 0, 1, 0, 5'd1, 32'h8000_0000, "R2 zero fill");
        chk("R2 directed", result, 32'h4000_0000);
        run_op(0, 0, 1, 0, 5'd1, 32'h4000_000F, "R1 left");
        chk("R1 directed", result, 32'h8000_001E);
        chk("R8 directed sign", {31'd0, flag_s}, 32'd1);
        run_op(1, 0, 0, 32'd4, 5'd0, 32'h0000_0008, "R5 right out");
        chk("R5 directed carry", {31'd0, flag_cy}, 32'd1);
        chk("R8 directed zero", {31'd0, flag_z}, 32'd1);
        run_op(0, 0, 1, 0, 5'd1, 32'h8000_0000, "R5 left out");
        chk("R5 directed left carry", {31'd0, flag_cy}, 32'd1);
        run_op(1, 1, 0, 32'd0, 5'd0, 32'hFFFF_FFFF, "R6 zero count reg");
        chk("R6 directed carry", {31'd0, flag_cy}, 32'd0);
        run_op(0, 0, 1, 32'd7, 5'd0, 32'hFFFF_FFFF, "R6 zero count imm");
        chk("R6 directed imm carry", {31'd0, flag_cy}, 32'd0);
        run_op(1, 0, 0, 32'h0000_0021, 5'd9, 32'h0000_0006, "R4 wrap");
        chk("R4 directed wrap", result, 32'h0000_0003);
        run_op(0, 1, 1, 32'd3, 5'd4, 32'h8000_0001, "R1 arith ignored");
        chk("R1 directed arith ignored", result, 32'h0000_0010);
        run_op(1, 1, 1, 0, 5'd31, 32'h8000_0000, "R3 full width");
        chk("R3 directed all ones", result, 32'hFFFF_FFFF);

        // Idle cycle with new inputs: flags must not move.
        @(negedge clk);
        data_in = 32'h0; count_use_imm = 1'b1; count_imm = 5'd0;
        @(negedge clk);
        chk("R9 hold", {28'd0, flag_cy, flag_ov, flag_s, flag_z},
            {28'd0, last_flags});
        chk("R9 valid idle", {31'd0, flags_valid}, 32'd0);

        for (int t = 0; t < 300; t++) begin
            logic rr = 1'($urandom);
            logic aa = 1'($urandom);
            logic ii = 1'($urandom);
            logic [31:0] cr = $urandom;
            logic [31:0] dd = $urandom;
            if (t % 7 == 0) dd = dd & 32'h0000_00FF;
            run_op(rr, aa, ii, cr, 5'($urandom), dd,
                   rr ? (aa ? "R3 random" : "R2 random") : "R1 random");
            if (t % 10 == 0) begin
                @(negedge clk);
                data_in = $urandom;
                @(negedge clk);
                chk("R9 hold random", {28'd0, flag_cy, flag_ov, flag_s, flag_z},
                    {28'd0, last_flags});
            end
        end

        // Reset in mid-run clears the flags again.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 reset again", {27'd0, flag_cy, flag_ov, flag_s, flag_z,
            flags_valid}, 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule